// File: doc/BRIEF.md
# Burst-Ordered Handshake Controller

This block is a clocked, cycle-accurate model of a four-state controller that moves on input bursts. It watches three level inputs, `inA`, `inB` and `inC`, and drives two outputs, `outX` and `outY`. A transition fires only when every compulsory edge of the burst expected in the current state has arrived. The edges of a burst may come in any order. One input of one burst is a directed don't-care: it may wander freely during that transition and is judged only when a later burst gives it a definite end value.

The inputs pass through a two-flop synchroniser on a fast sampling clock. Each synchronised input is then compared with the value it had on entry to the current state. When a burst completes, the output burst is registered first. The internal state advances on the following edge. During that settle cycle the inputs are not judged.

An input that moves in a way the pending burst forbids sets a sticky `protocolError`. The controller then freezes its state and outputs until reset.

Top module: `ebm_controller`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in its idle state (inputs 000 expected) with `outX`=0, `outY`=0 and `protocolError`=0.
- R2: Each input passes through `SYNC_STAGES` flops (default 2). An input change set up before a rising edge therefore affects the outputs on the third rising edge, counting that edge as the first.
- R3: In the idle state, `inA` rising while `inC` stays 0 sets `outX`=1 and `outY`=1 and leads to the second state. `inB` may toggle freely during this transition.
- R4: In the second state, both `inB`=1 and `inC`=1 are needed, in either order, to set `outX`=0 with `outY` held at 1 and to enter the third state. A partial burst leaves the outputs unchanged.
- R5: In the third state (inputs 111), `inC` falling sets `outX`=1 and `outY`=0 and leads to the fourth state.
- R6: In the fourth state (inputs 110), both `inA`=0 and `inB`=0 are needed, in either order, to clear `outX` and `outY` and return to idle. A partial burst changes nothing.
- R7: The output burst is registered one edge before the state changes. In that settle cycle the inputs are not judged, so edges of the next burst that arrive then are neither errors nor lost.
- R8: A forbidden input value sets `protocolError` one edge after it is synchronised. The forbidden values are `inC`=1 in idle, `inA`=0 in the second state, `inA` or `inB` at 0 in the third state, and `inC`=1 in the fourth state. The flag stays set, and the outputs and state stay frozen, until reset.
- R9: `inB` is a don't-care on entry to the second state. If it is already 1 on entry, `inC` rising alone completes that state's burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| inA | input | 1 | Level input a |
| inB | input | 1 | Level input b |
| inC | input | 1 | Level input c |
| outX | output | 1 | Output x |
| outY | output | 1 | Output y |
| protocolError | output | 1 | Sticky flag for an input move the burst forbids |

## Verification
The bench drives the second and fourth bursts in both edge orders and holds partial bursts for several cycles. A design that fired on the first edge would change its outputs early. It toggles `inB` during the first burst and enters the second state with `inB` already high. A design that checked the don't-care, or that waited for a fresh `inB` edge, would raise an error or stall. It lands an edge of the next burst exactly in the settle cycle. A design that moved state and outputs together would judge that edge against the old entry value and flag an error. Finally, it forces forbidden moves in the idle and third states and then offers valid bursts. A non-sticky flag, or outputs that still moved, would show at the pins.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RISEN = 2'd1,
    ST_FULL  = 2'd2,
    ST_HALF  = 2'd3
  } ctrlStateT;

  typedef struct packed {
    logic       loadOut;
    logic [1:0] outVal;
    logic       setErr;
  } strobeT;

  function automatic ctrlStateT nextOf(input ctrlStateT cur);
    case (cur)
      ST_IDLE:  nextOf = ST_RISEN;
      ST_RISEN: nextOf = ST_FULL;
      ST_FULL:  nextOf = ST_HALF;
      default:  nextOf = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/ebm_datapath.sv
module ebm_datapath
  import ebm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IN_WIDTH    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IN_WIDTH-1:0] rawIn,
  input  strobeT              strobes,
  output logic [IN_WIDTH-1:0] syncIn,
  output logic                outX,
  output logic                outY,
  output logic                errFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][IN_WIDTH-1:0] chain;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain[0] <= rawIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign syncIn = chain[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      outX    <= 1'b0;
      outY    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobes.setErr)  errFlag <= 1'b1;
      if (strobes.loadOut) {outX, outY} <= strobes.outVal;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!outX && !outY && !errFlag));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  assert_out_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> $stable({outX, outY}));

  assert_out_from_load_R7: assert property (@(posedge clk) disable iff (rst)
    ({outX, outY} != $past({outX, outY})) |-> ($past(strobes.loadOut) || $past(rst)));

endmodule

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
  import ebm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] syncIn,
  input  logic       errSeen,
  output strobeT     strobes
);

  ctrlStateT state;
  logic      settle;
  logic      sigA, sigB, sigC;
  logic      burstDone, burstBad, judge;
  logic [1:0] target;

  assign {sigA, sigB, sigC} = syncIn;

  always_comb begin
    burstDone = 1'b0;
    burstBad  = 1'b0;
    target    = 2'b00;
    case (state)
      ST_IDLE: begin
        burstBad  = sigC;
        burstDone = sigA;
        target    = 2'b11;
      end
      ST_RISEN: begin
        burstBad  = !sigA;
        burstDone = sigB && sigC;
        target    = 2'b01;
      end
      ST_FULL: begin
        burstBad  = !sigA || !sigB;
        burstDone = !sigC;
        target    = 2'b10;
      end
      default: begin
        burstBad  = sigC;
        burstDone = !sigA && !sigB;
        target    = 2'b00;
      end
    endcase
  end

  assign judge           = !settle && !errSeen;
  assign strobes.setErr  = judge && burstBad;
  assign strobes.loadOut = judge && burstDone && !burstBad;
  assign strobes.outVal  = target;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      settle <= 1'b0;
    end else if (settle) begin
      state  <= nextOf(state);
      settle <= 1'b0;
    end else if (strobes.loadOut) begin
      settle <= 1'b1;
    end
  end

  assert_state_after_out_R7: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> $past(settle));

  assert_no_double_load_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.loadOut |=> !strobes.loadOut);

endmodule

// File: rtl/ebm_controller.sv
module ebm_controller
  import ebm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic outX,
  output logic outY,
  output logic protocolError
);

  strobeT     strobes;
  logic [2:0] syncIn;

  ebm_datapath #(.SYNC_STAGES(SYNC_STAGES), .IN_WIDTH(3)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .rawIn   ({inA, inB, inC}),
    .strobes (strobes),
    .syncIn  (syncIn),
    .outX    (outX),
    .outY    (outY),
    .errFlag (protocolError)
  );

  ebm_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .syncIn  (syncIn),
    .errSeen (protocolError),
    .strobes (strobes)
  );

endmodule

// File: tb/ebm_controller_bench.sv
module ebm_controller_bench;

  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pinA = 1'b0, pinB = 1'b0, pinC = 1'b0;
  logic outX, outY, protocolError;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit comparing = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  ebm_controller #(.SYNC_STAGES(STAGES)) u_ebm_controller (
    .clk(clk), .rst(rst), .inA(pinA), .inB(pinB), .inC(pinC),
    .outX(outX), .outY(outY), .protocolError(protocolError)
  );

  // behavioural reference
  logic [2:0] pipe[$];
  int  mState = 0;
  bit  mSettle = 0, mErr = 0, mX = 0, mY = 0;

  function automatic bit illegalMove(int st, logic [2:0] v);
    // v = {a,b,c}
    if (st == 0) return v[0];
    if (st == 1) return !v[2];
    if (st == 2) return (v[2] == 0) || (v[1] == 0);
    return v[0];
  endfunction

  function automatic bit arrived(int st, logic [2:0] v);
    if (st == 0) return v[2];
    if (st == 1) return v[1] && v[0];
    if (st == 2) return !v[0];
    return !v[2] && !v[1];
  endfunction

  always @(posedge clk) begin
    logic [2:0] oldest;
    cycles++;
    if (rst) begin
      pipe = {};
      for (int i = 0; i < STAGES; i++) pipe.push_back(3'b000);
      mState = 0; mSettle = 0; mErr = 0; mX = 0; mY = 0;
    end else begin
      oldest = pipe[0];
      if (mSettle) begin
        mState  = (mState + 1) % 4;
        mSettle = 0;
      end else if (!mErr) begin
        if (illegalMove(mState, oldest)) mErr = 1;
        else if (arrived(mState, oldest)) begin
          case (mState)
            0: begin mX = 1; mY = 1; end
            1: begin mX = 0; mY = 1; end
            2: begin mX = 1; mY = 0; end
            default: begin mX = 0; mY = 0; end
          endcase
          mSettle = 1;
        end
      end
      void'(pipe.pop_front());
      pipe.push_back({pinA, pinB, pinC});
    end
  end

  task automatic compareNow();
    checks++;
    if ({outX, outY, protocolError} !== {mX, mY, mErr}) begin
      errors++;
      $display("FAIL %s: actual xy/err=%b%b/%b expected %b%b/%b at cycle %0d",
               curReq, outX, outY, protocolError, mX, mY, mErr, cycles);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (comparing) compareNow();
    end
  endtask

  task automatic drive(logic a, logic b, logic c);
    tick(1);
    pinA = a; pinB = b; pinC = c;
  endtask

  task automatic expectPins(string req, logic ex, logic ey, logic ee);
    checks++;
    if ({outX, outY, protocolError} !== {ex, ey, ee}) begin
      errors++;
      $display("FAIL %s: actual xy/err=%b%b/%b expected %b%b/%b",
               req, outX, outY, protocolError, ex, ey, ee);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; pinA = 0; pinB = 0; pinC = 0;
    tick(3);
    rst = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    comparing = 1;
    doReset();
    curReq = "R1";
    tick(1);
    expectPins("R1", 0, 0, 0);

    // R2: latency of a single input edge
    curReq = "R2";
    drive(1, 0, 0);
    tick(2);
    expectPins("R2", 0, 0, 0);
    tick(1);
    expectPins("R2", 1, 1, 0);
    tick(3);
    // R9: b already up on entry would have let c alone finish; here b low
    curReq = "R4";
    drive(1, 0, 1);   // c first, partial
    tick(5);
    expectPins("R4", 1, 1, 0);
    drive(1, 1, 1);
    tick(5);
    expectPins("R4", 0, 1, 0);
    curReq = "R5";
    drive(1, 1, 0);
    tick(5);
    expectPins("R5", 1, 0, 0);
    curReq = "R6";
    drive(1, 0, 0);   // b first, partial
    tick(5);
    expectPins("R6", 1, 0, 0);
    drive(0, 0, 0);
    tick(5);
    expectPins("R6", 0, 0, 0);

    // R3 with b toggling, then R9 entry with b high
    curReq = "R3";
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    tick(4);
    expectPins("R3", 0, 0, 0);
    drive(1, 0, 0);
    drive(1, 1, 0);
    drive(1, 0, 0);
    drive(1, 1, 0);
    tick(5);
    expectPins("R3", 1, 1, 0);
    curReq = "R9";
    drive(1, 1, 1);
    tick(5);
    expectPins("R9", 0, 1, 0);
    curReq = "R5";
    drive(1, 1, 0);
    tick(5);
    curReq = "R6";
    drive(0, 1, 0);   // a first
    tick(4);
    expectPins("R6", 1, 0, 0);
    drive(0, 0, 0);
    tick(5);
    expectPins("R6", 0, 0, 0);

    // R7: next burst edge lands in the settle cycle
    curReq = "R7";
    drive(1, 1, 0);
    drive(1, 1, 1);
    tick(6);
    expectPins("R7", 0, 1, 0);
    drive(1, 1, 0);
    tick(5);
    drive(0, 0, 0);
    tick(5);
    expectPins("R7", 0, 0, 0);

    // R8: forbidden move in idle, then sticky freeze
    curReq = "R8";
    drive(0, 0, 1);
    tick(4);
    expectPins("R8", 0, 0, 1);
    drive(1, 0, 0);
    tick(6);
    expectPins("R8", 0, 0, 1);
    doReset();
    curReq = "R1";
    tick(1);
    expectPins("R1", 0, 0, 0);

    // R8: forbidden move in the third state
    curReq = "R8";
    drive(1, 1, 0);
    tick(5);
    drive(1, 1, 1);
    tick(5);
    drive(1, 0, 1);
    tick(4);
    expectPins("R8", 0, 1, 1);
    drive(1, 1, 0);
    tick(6);
    expectPins("R8", 0, 1, 1);
    doReset();
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule